// File: doc/BRIEF.md
# Transmit Jabber Guard and Heartbeat Collision Generator

This block watches the transmit-enable line of a twisted-pair port and drives the collision indication back to the media access controller. A transmission held on for too long is treated as runaway: the block inhibits the line transmitter and holds collision high. The lockout persists until transmit enable has stayed low for a much longer recovery interval. A rise of transmit enable during that interval starts the interval again.

After every packet that ends normally while the link is good, the block raises collision for a short, fixed window a short, fixed time after transmit enable falls. This heartbeat lets the controller confirm that its collision path works. While a packet is being sent and the receiver reports activity on a good link, collision is also asserted.

All timing is counted in ticks of a 10 MHz enable. A speedup input swaps the long trip and release limits for short ones, so that both can be exercised in a short simulation.

Top module: `jabber_sqe_ctrl`

## Requirements
- R1: While reset is high, and on the first cycle after it, both `col` and `tx_inhibit` are 0.
- R2: `tx_inhibit` goes to 1 on the clock edge where transmit enable has been sampled high on the trip-limit-th consecutive tick. `col` follows one clock later. Fewer ticks with transmit enable high do not trip the guard.
- R3: Once locked, `tx_inhibit` and (one clock later) `col` return to 0 on the edge of the release-limit-th consecutive tick with transmit enable low.
- R4: When transmit enable falls, link is good and the guard is not locked, `col` goes high after a delay of SQE_DLY ticks (plus one register) and stays high for exactly SQE_WID ticks. With the defaults (10 and 10 ticks, a tick every 5 clocks) that is 50 clocks.
- R5: `col` is 1 one clock after any cycle where `tx_en`, `rx_active` and `link_ok` are all 1. Receive activity with `tx_en` low does not raise `col`.
- R6: No heartbeat pulse follows a packet that ends while the guard is locked, or while `link_ok` is 0.
- R7: In the locked state, any cycle with `tx_en` high clears the low-time count, so release needs the full release limit of low ticks counted again from that point.
- R8: `speedup` = 1 selects the short limits (46 and 368 ticks by default). `speedup` = 0 selects the long ones (460000 and 3680000 ticks, i.e. 46 ms and 368 ms at 10 MHz).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_10m | input | 1 | One-cycle enable at 10 MHz; every timer counts only on it |
| tx_en | input | 1 | Transmit enable from the controller |
| rx_active | input | 1 | Receive activity present on the twisted pair |
| link_ok | input | 1 | Link test passing; twisted-pair operation active |
| speedup | input | 1 | Selects the short trip and release limits |
| tx_inhibit | output | 1 | Registered; disables the twisted-pair transmitter while jabbering |
| col | output | 1 | Registered collision indication toward the controller |

## Verification
Several relations are checked on every cycle: a lockout starts only when transmit enable was high, ends only when it was low, and forces collision on the next clock. Overlap of receive and transmit activity always yields collision. A transmit-enable rise in the locked state clears the low-time count, and a packet ending under lockout never arms a heartbeat. The exact heartbeat delay and width, the absence of a trip just below the limit, and a release delayed by an early transmit-enable rise can only be shown by the bench. It does so by running packets, overlaps, link-down packets and a full jabber-and-recovery sequence against its cycle-level reference model.

// File: rtl/jsq_pkg.sv
package jsq_pkg;

  typedef enum logic {
    JB_ARMED  = 1'b0,
    JB_LOCKED = 1'b1
  } jab_state_t;

  typedef enum logic [1:0] {
    HB_IDLE  = 2'd0,
    HB_WAIT  = 2'd1,
    HB_PULSE = 2'd2
  } hb_state_t;

endpackage

// File: rtl/jsq_limit_sel.sv
module jsq_limit_sel #(
  parameter int CW         = 22,
  parameter int TRIP_TICKS = 460000,
  parameter int REL_TICKS  = 3680000,
  parameter int FAST_TRIP  = 46,
  parameter int FAST_REL   = 368
) (
  input  logic          speedup,
  output logic [CW-1:0] trip_lim,
  output logic [CW-1:0] rel_lim
);

  localparam logic [CW-1:0] TRIP_L = CW'(TRIP_TICKS);
  localparam logic [CW-1:0] REL_L  = CW'(REL_TICKS);
  localparam logic [CW-1:0] TRIP_S = CW'(FAST_TRIP);
  localparam logic [CW-1:0] REL_S  = CW'(FAST_REL);

  always_comb begin
    trip_lim = speedup ? TRIP_S : TRIP_L;
    rel_lim  = speedup ? REL_S  : REL_L;
  end

endmodule

// File: rtl/jsq_jab_guard.sv
module jsq_jab_guard
  import jsq_pkg::*;
#(
  parameter int CW = 22
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic          tx_en,
  input  logic [CW-1:0] trip_lim,
  input  logic [CW-1:0] rel_lim,
  output logic          locked
);

  jab_state_t    st;
  logic [CW-1:0] hi_cnt;
  logic [CW-1:0] lo_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= JB_ARMED;
      hi_cnt <= '0;
      lo_cnt <= '0;
    end else begin
      case (st)
        JB_ARMED: begin
          lo_cnt <= '0;
          if (!tx_en) begin
            hi_cnt <= '0;
          end else if (tick) begin
            if (hi_cnt == trip_lim - CW'(1)) begin
              st     <= JB_LOCKED;
              hi_cnt <= '0;
            end else begin
              hi_cnt <= hi_cnt + CW'(1);
            end
          end
        end
        default: begin
          hi_cnt <= '0;
          if (tx_en) begin
            lo_cnt <= '0;
          end else if (tick) begin
            if (lo_cnt == rel_lim - CW'(1)) begin
              st     <= JB_ARMED;
              lo_cnt <= '0;
            end else begin
              lo_cnt <= lo_cnt + CW'(1);
            end
          end
        end
      endcase
    end
  end

  assign locked = (st == JB_LOCKED);

  // lockout is entered only from a cycle with transmit enable high
  assert_trip_needs_txen_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(locked) |-> $past(tx_en));

  // lockout is left only from a cycle with transmit enable low
  assert_release_needs_low_R3: assert property (@(posedge clk) disable iff (rst)
    $fell(locked) |-> !$past(tx_en));

  // an early rise during recovery restarts the low-time count
  assert_restart_low_count_R7: assert property (@(posedge clk) disable iff (rst)
    (locked && tx_en) |=> (lo_cnt == '0));

endmodule

// File: rtl/jsq_heartbeat.sv
module jsq_heartbeat
  import jsq_pkg::*;
#(
  parameter int SQE_DLY = 10,
  parameter int SQE_WID = 10
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic tx_en,
  input  logic locked,
  input  logic link_ok,
  output logic pulse_on
);

  localparam int HMAX = (SQE_DLY > SQE_WID) ? SQE_DLY : SQE_WID;
  localparam int HW   = $clog2(HMAX + 1);
  localparam logic [HW-1:0] DLY_END = HW'(SQE_DLY - 1);
  localparam logic [HW-1:0] WID_END = HW'(SQE_WID - 1);

  hb_state_t     st;
  logic [HW-1:0] cnt;
  logic          tx_q;
  logic          tx_fall;

  assign tx_fall = tx_q & ~tx_en;

  always_ff @(posedge clk) begin
    if (rst) begin
      st   <= HB_IDLE;
      cnt  <= '0;
      tx_q <= 1'b0;
    end else begin
      tx_q <= tx_en;
      case (st)
        HB_IDLE: begin
          cnt <= '0;
          if (tx_fall && !locked && link_ok) st <= HB_WAIT;
        end
        HB_WAIT: begin
          if (tx_en || !link_ok) begin
            st  <= HB_IDLE;
            cnt <= '0;
          end else if (tick) begin
            if (cnt == DLY_END) begin
              st  <= HB_PULSE;
              cnt <= '0;
            end else begin
              cnt <= cnt + HW'(1);
            end
          end
        end
        default: begin
          if (tx_en || !link_ok) begin
            st  <= HB_IDLE;
            cnt <= '0;
          end else if (tick) begin
            if (cnt == WID_END) begin
              st  <= HB_IDLE;
              cnt <= '0;
            end else begin
              cnt <= cnt + HW'(1);
            end
          end
        end
      endcase
    end
  end

  assign pulse_on = (st == HB_PULSE);

  // a packet ending under lockout or with link down arms nothing
  assert_no_beat_when_blocked_R6: assert property (@(posedge clk) disable iff (rst)
    (st == HB_IDLE && tx_fall && (locked || !link_ok)) |=> (st == HB_IDLE));

  // the pulse is only ever reached through the delay phase
  assert_pulse_after_wait_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(pulse_on) |-> ($past(st) == HB_WAIT));

endmodule

// File: rtl/jabber_sqe_ctrl.sv
module jabber_sqe_ctrl
  import jsq_pkg::*;
#(
  parameter int TRIP_TICKS = 460000,
  parameter int REL_TICKS  = 3680000,
  parameter int FAST_TRIP  = 46,
  parameter int FAST_REL   = 368,
  parameter int SQE_DLY    = 10,
  parameter int SQE_WID    = 10
) (
  input  logic clk,
  input  logic rst,
  input  logic tick_10m,
  input  logic tx_en,
  input  logic rx_active,
  input  logic link_ok,
  input  logic speedup,
  output logic tx_inhibit,
  output logic col
);

  localparam int MAXL = (REL_TICKS > TRIP_TICKS) ? REL_TICKS : TRIP_TICKS;
  localparam int MAXF = (FAST_REL > FAST_TRIP) ? FAST_REL : FAST_TRIP;
  localparam int MAXA = (MAXL > MAXF) ? MAXL : MAXF;
  localparam int CW   = $clog2(MAXA + 1);

  logic [CW-1:0] trip_lim;
  logic [CW-1:0] rel_lim;
  logic          locked;
  logic          pulse_on;
  logic          col_q;

  jsq_limit_sel #(
    .CW(CW), .TRIP_TICKS(TRIP_TICKS), .REL_TICKS(REL_TICKS),
    .FAST_TRIP(FAST_TRIP), .FAST_REL(FAST_REL)
  ) u_lim (
    .speedup (speedup),
    .trip_lim(trip_lim),
    .rel_lim (rel_lim)
  );

  jsq_jab_guard #(.CW(CW)) u_guard (
    .clk     (clk),
    .rst     (rst),
    .tick    (tick_10m),
    .tx_en   (tx_en),
    .trip_lim(trip_lim),
    .rel_lim (rel_lim),
    .locked  (locked)
  );

  jsq_heartbeat #(.SQE_DLY(SQE_DLY), .SQE_WID(SQE_WID)) u_beat (
    .clk     (clk),
    .rst     (rst),
    .tick    (tick_10m),
    .tx_en   (tx_en),
    .locked  (locked),
    .link_ok (link_ok),
    .pulse_on(pulse_on)
  );

  always_ff @(posedge clk) begin
    if (rst) col_q <= 1'b0;
    else     col_q <= locked | pulse_on | (tx_en & rx_active & link_ok);
  end

  assign col        = col_q;
  assign tx_inhibit = locked;

  // lockout forces collision on the following clock
  assert_col_follows_lock_R2: assert property (@(posedge clk) disable iff (rst)
    tx_inhibit |=> col);

  // transmit and receive overlap on a good link raises collision
  assert_overlap_col_R5: assert property (@(posedge clk) disable iff (rst)
    (tx_en && rx_active && link_ok) |=> col);

  // collision drops only when none of its causes was present
  assert_col_drop_clean_R4: assert property (@(posedge clk) disable iff (rst)
    $fell(col) |-> !$past(locked));

endmodule

// File: tb/test_jabber_sqe_ctrl.sv
module test_jabber_sqe_ctrl;

  localparam int FTRIP = 46;
  localparam int FREL  = 368;
  localparam int STRIP = 460000;
  localparam int SREL  = 3680000;
  localparam int DLY   = 10;
  localparam int WID   = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick_10m = 1'b0;
  logic tx_en = 1'b0;
  logic rx_active = 1'b0;
  logic link_ok = 1'b1;
  logic speedup = 1'b1;
  logic tx_inhibit;
  logic col;

  int total = 0;
  int bad = 0;
  bit done = 0;
  string cur_req = "R1";

  always #10 clk = ~clk;

  jabber_sqe_ctrl i_jabber_sqe_ctrl (
    .clk(clk), .rst(rst), .tick_10m(tick_10m), .tx_en(tx_en),
    .rx_active(rx_active), .link_ok(link_ok), .speedup(speedup),
    .tx_inhibit(tx_inhibit), .col(col)
  );

  // tick every fifth clock
  int tdiv = 0;
  always @(negedge clk) begin
    tdiv = (tdiv == 4) ? 0 : tdiv + 1;
    tick_10m <= (tdiv == 0);
  end

  // behavioural reference model
  int m_lock = 0, m_hi = 0, m_lo = 0, m_txq = 0, m_hb = 0, m_hc = 0, m_col = 0;
  always @(posedge clk) begin
    int n_col, trip, rel;
    trip = speedup ? FTRIP : STRIP;
    rel  = speedup ? FREL  : SREL;
    if (rst) begin
      m_lock = 0; m_hi = 0; m_lo = 0; m_txq = 0; m_hb = 0; m_hc = 0; m_col = 0;
    end else begin
      n_col = (m_lock || m_hb == 2 || (tx_en && rx_active && link_ok)) ? 1 : 0;
      // heartbeat
      if (m_hb == 0) begin
        m_hc = 0;
        if (m_txq == 1 && !tx_en && m_lock == 0 && link_ok) m_hb = 1;
      end else if (tx_en || !link_ok) begin
        m_hb = 0; m_hc = 0;
      end else if (tick_10m) begin
        m_hc++;
        if (m_hb == 1 && m_hc == DLY) begin m_hb = 2; m_hc = 0; end
        else if (m_hb == 2 && m_hc == WID) begin m_hb = 0; m_hc = 0; end
      end
      // jabber guard
      if (m_lock == 0) begin
        m_lo = 0;
        if (!tx_en) m_hi = 0;
        else if (tick_10m) begin
          m_hi++;
          if (m_hi == trip) begin m_lock = 1; m_hi = 0; end
        end
      end else begin
        m_hi = 0;
        if (tx_en) m_lo = 0;
        else if (tick_10m) begin
          m_lo++;
          if (m_lo == rel) begin m_lock = 0; m_lo = 0; end
        end
      end
      m_txq = tx_en ? 1 : 0;
      m_col = n_col;
    end
  end

  // compare on every clock
  always @(negedge clk) begin
    if (!rst && !done) begin
      total++;
      if (col !== m_col[0] || tx_inhibit !== m_lock[0]) begin
        bad++;
        $display("FAIL %s model compare: col=%0b inh=%0b expected col=%0d inh=%0d",
                 cur_req, col, tx_inhibit, m_col, m_lock);
      end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    int d, w, seen;
    step(5);
    chk(col == 1'b0, "R1 col in reset", col, 0);
    chk(tx_inhibit == 1'b0, "R1 inhibit in reset", tx_inhibit, 0);
    rst = 1'b0;
    step(1);
    chk(col == 1'b0 && tx_inhibit == 1'b0, "R1 after reset", {30'd0, col, tx_inhibit}, 0);

    // normal packet and heartbeat
    cur_req = "R4";
    tx_en = 1'b1; step(100);
    chk(col == 1'b0, "R5 no col without receive", col, 0);
    tx_en = 1'b0;
    d = 0;
    while (!col && d < 80) begin step(1); d++; end
    chk(d >= 47 && d <= 53, "R4 heartbeat delay", d, 50);
    w = 0;
    while (col && w < 100) begin w++; step(1); end
    chk(w == 50, "R4 heartbeat width", w, 50);
    step(20);

    // overlap
    cur_req = "R5";
    tx_en = 1'b1; step(20);
    rx_active = 1'b1; step(3);
    chk(col == 1'b1, "R5 overlap col", col, 1);
    rx_active = 1'b0; step(3);
    chk(col == 1'b0, "R5 overlap ended", col, 0);
    tx_en = 1'b0; step(120);
    rx_active = 1'b1; step(5);
    chk(col == 1'b0, "R5 receive alone", col, 0);
    rx_active = 1'b0; step(5);

    // link down: no heartbeat
    cur_req = "R6";
    link_ok = 1'b0;
    tx_en = 1'b1; step(50);
    tx_en = 1'b0;
    seen = 0;
    for (int i = 0; i < 120; i++) begin step(1); if (col) seen++; end
    chk(seen == 0, "R6 no beat with link down", seen, 0);
    link_ok = 1'b1; step(5);

    // just below trip
    cur_req = "R2";
    tx_en = 1'b1; step(200);
    chk(tx_inhibit == 1'b0, "R2 below trip", tx_inhibit, 0);
    tx_en = 1'b0; step(120);

    // long limits selected
    cur_req = "R8";
    speedup = 1'b0;
    tx_en = 1'b1; step(300);
    chk(tx_inhibit == 1'b0, "R8 long limit no trip", tx_inhibit, 0);
    tx_en = 1'b0; step(120);
    speedup = 1'b1; step(5);

    // jabber trip
    cur_req = "R2";
    tx_en = 1'b1; step(240);
    chk(tx_inhibit == 1'b1, "R8 short limit trips R2", tx_inhibit, 1);
    step(2);
    chk(col == 1'b1, "R2 col during jabber", col, 1);
    step(50);
    cur_req = "R6";
    tx_en = 1'b0; step(1000);
    chk(tx_inhibit == 1'b1, "R3 still locked", tx_inhibit, 1);
    cur_req = "R7";
    tx_en = 1'b1; step(10);
    tx_en = 1'b0; step(1500);
    chk(tx_inhibit == 1'b1, "R7 release restarted", tx_inhibit, 1);
    cur_req = "R3";
    step(400);
    chk(tx_inhibit == 1'b0, "R3 released", tx_inhibit, 0);
    chk(col == 1'b0, "R3 col released", col, 0);
    seen = 0;
    for (int i = 0; i < 100; i++) begin step(1); if (col) seen++; end
    chk(seen == 0, "R6 no beat after jabber", seen, 0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog expired in %s", cur_req);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule